// File: doc/BRIEF.md
# Masked Burst Write Target Controller

This block is the device-side end of a multi-cycle burst write on a shared command and data bus. A host places a write command on the command lines together with a routing word on the data bus. The device compares the routing word's identity field with its own identity; a match, or the all-ones broadcast identity, makes it take part. The same word picks one of two on-chip arrays. The words that follow go to consecutive locations taken from an internal start address that software programmed earlier.

Each word updates only the bit positions that are set in one of eight global mask words. The mask word is chosen by an index carried in the command. While the burst runs, the device drives a status pin in a fixed low/high/low pattern and then releases it. A device that does not take part still counts the burst, so that the data words that follow are never taken for commands.

A small programming port loads the mask words and the burst configuration (start address and length). Readback ports let a bench inspect both arrays.

Top module: `burst_wr_target`

## Requirements
- R1: After reset, eot_oe and eot_out are 0, every entry of both arrays reads 0, all eight mask words are 0, and the start address and length are 0.
- R2: A command is accepted only when the block is idle and, in the same cycle, cmd_valid=1, cmd[2]=1 and cmd[1:0]=2'b01. The device is selected when dq[25:21] equals parameter DEV_ID (default 3), or when dq[25:21]=5'b11111.
- R3: dq[20:19] in the command cycle picks the target: 2'b00 is the data array (rd_arr=0) and 2'b01 is the mask array (rd_arr=1). The codes 2'b1x make the device unselected. All other command-cycle dq bits have no effect.
- R4: With burst length n, the dq word of each cycle from 2 through n+1 (cycle 1 being the command cycle) is written to the selected array. Only the bits that are 1 in mask word cmd[5:3], as sampled in the command cycle, take the new value; the other bits keep their stored value.
- R5: Successive words go to successive addresses starting at the programmed start address. The 14-bit address wraps from 16383 to 0, and the arrays use its low 4 bits. After a burst the stored address holds the value after the last word, so the next burst continues from there unless the address is reprogrammed.
- R6: For a selected device, eot_oe is 1 exactly in cycles 3 through n+2. eot_out is 1 only in cycle n+1 and is 0 in every other enabled cycle. In cycle n+3 eot_oe is 0 again.
- R7: A programmed burst length of 0 behaves as a length of 1.
- R8: An unselected device writes nothing and keeps eot_oe at 0. Any device ignores cmd_valid for cycles 2 through n+2 of a burst, and accepts a new command in cycle n+3.
- R9: A write with cfg_we=1 and cfg_addr=0..7 loads that mask word from cfg_wdata. With cfg_addr=8 it loads the start address from cfg_wdata[13:0] and the length from cfg_wdata[23:16]. Writes to address 8 have no effect while a burst runs or in the cycle a command is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command lines carry a command |
| cmd | input | 6 | [1:0] opcode, [2] write class, [5:3] mask word index |
| dq | input | 68 | Routing word in the command cycle, data word in the data cycles |
| eot_out | output | 1 | End-of-transfer level |
| eot_oe | output | 1 | Output enable of the end-of-transfer pin |
| cfg_we | input | 1 | Programming write strobe |
| cfg_addr | input | 4 | Programming target: 0..7 mask words, 8 burst configuration |
| cfg_wdata | input | 68 | Programming write data |
| rd_arr | input | 1 | Readback array: 0 data, 1 mask |
| rd_addr | input | 4 | Readback entry |
| rd_data | output | 68 | Readback word |

## Verification
The bench builds the block with the default parameters: a 68-bit bus, a 14-bit address, 16-entry arrays, an 8-bit length field and identity 3. The short arrays bring two wraps within reach of a few dozen bursts: wrap across the array depth, and wrap of the full 14-bit address from 16383 to 0. Lengths range from 0 to 12, so the degenerate one-word burst, where the high phase of the status pin falls before the enable, is covered alongside longer bursts. Other identities, reserved array codes and stray commands during the data cycles test the non-participating path.

// File: rtl/bwt_pkg.sv
package bwt_pkg;
   typedef enum logic [1:0] {
      ARR_DATA = 2'b00,
      ARR_MASK = 2'b01,
      ARR_RSV2 = 2'b10,
      ARR_RSV3 = 2'b11
   } arr_sel_e;

   localparam logic [1:0] OP_WRITE = 2'b01;
   localparam int         CFG_LEN_LSB = 16;
endpackage

// File: rtl/bwt_cmd_decode.sv
module bwt_cmd_decode #(
   parameter int DW      = 68,
   parameter int ID_W    = 5,
   parameter int ID_LSB  = 21,
   parameter int SEL_LSB = 19,
   parameter int MIDX_W  = 3,
   parameter logic [ID_W-1:0] DEV_ID = 5'd3
) (
   input  logic                   cmd_valid,
   input  logic [MIDX_W+2:0]      cmd,
   input  logic [DW-1:0]          dq,
   output logic                   is_write,
   output logic                   selected,
   output bwt_pkg::arr_sel_e      arr,
   output logic [MIDX_W-1:0]      midx
);
   import bwt_pkg::*;

   logic [ID_W-1:0] id_field;
   logic            id_hit;

   assign id_field = dq[ID_LSB +: ID_W];
   assign id_hit   = (id_field == DEV_ID) || (id_field == {ID_W{1'b1}});
   assign arr      = arr_sel_e'(dq[SEL_LSB +: 2]);
   assign midx     = cmd[MIDX_W+2:3];
   assign is_write = cmd_valid && cmd[2] && (cmd[1:0] == OP_WRITE);
   assign selected = id_hit && ((arr == ARR_DATA) || (arr == ARR_MASK));
endmodule

// File: rtl/bwt_sequencer.sv
module bwt_sequencer #(
   parameter int BLEN_W = 8,
   parameter int MIDX_W = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic                 start_sel,
   input  bwt_pkg::arr_sel_e    start_arr,
   input  logic [MIDX_W-1:0]    start_midx,
   input  logic [BLEN_W-1:0]    blen,
   output logic                 accept,
   output logic                 busy,
   output logic                 wr_en,
   output bwt_pkg::arr_sel_e    arr_q,
   output logic [MIDX_W-1:0]    midx_q,
   output logic                 eot_out,
   output logic                 eot_oe
);
   import bwt_pkg::*;

   localparam int CW = BLEN_W + 2;

   logic [CW-1:0] cyc_q;
   logic [CW-1:0] n_q;
   logic          sel_q;
   logic          busy_q;

   assign accept = start && !busy_q;
   assign busy   = busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cyc_q  <= '0;
         n_q    <= '0;
         sel_q  <= 1'b0;
         arr_q  <= ARR_DATA;
         midx_q <= '0;
      end else if (accept) begin
         busy_q <= 1'b1;
         cyc_q  <= CW'(2);
         n_q    <= (blen == '0) ? CW'(1) : CW'(blen);
         sel_q  <= start_sel;
         arr_q  <= start_arr;
         midx_q <= start_midx;
      end else if (busy_q) begin
         if (cyc_q == n_q + CW'(2)) begin
            busy_q <= 1'b0;
            cyc_q  <= '0;
            sel_q  <= 1'b0;
         end else begin
            cyc_q <= cyc_q + CW'(1);
         end
      end
   end

   assign wr_en   = busy_q && sel_q && (cyc_q <= n_q + CW'(1));
   assign eot_oe  = busy_q && sel_q && (cyc_q >= CW'(3));
   assign eot_out = eot_oe && (cyc_q == n_q + CW'(1));
endmodule

// File: rtl/bwt_cfg_regs.sv
module bwt_cfg_regs #(
   parameter int DW      = 68,
   parameter int AW      = 14,
   parameter int BLEN_W  = 8,
   parameter int MIDX_W  = 3,
   parameter int LEN_LSB = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [MIDX_W:0]    cfg_addr,
   input  logic [DW-1:0]      cfg_wdata,
   input  logic               lock,
   input  logic               inc,
   input  logic [MIDX_W-1:0]  midx,
   output logic [DW-1:0]      mask_word,
   output logic [AW-1:0]      burst_addr,
   output logic [BLEN_W-1:0]  blen
);
   localparam int NMASK = 1 << MIDX_W;

   if (LEN_LSB < AW) begin : g_bad_layout
      $error("length field overlaps the address field");
   end
   if (LEN_LSB + BLEN_W > DW) begin : g_bad_width
      $error("length field exceeds the data width");
   end

   logic [DW-1:0] mask_q [NMASK];
   logic          hit_burst;

   assign hit_burst = cfg_we && (cfg_addr == {1'b1, {MIDX_W{1'b0}}});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NMASK; i++) mask_q[i] <= '0;
      end else if (cfg_we && !cfg_addr[MIDX_W]) begin
         mask_q[cfg_addr[MIDX_W-1:0]] <= cfg_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         burst_addr <= '0;
         blen       <= '0;
      end else if (inc) begin
         burst_addr <= burst_addr + AW'(1);
      end else if (hit_burst && !lock) begin
         burst_addr <= cfg_wdata[AW-1:0];
         blen       <= cfg_wdata[LEN_LSB +: BLEN_W];
      end
   end

   assign mask_word = mask_q[midx];
endmodule

// File: rtl/bwt_array.sv
module bwt_array #(
   parameter int DW     = 68,
   parameter int ARR_AW = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ARR_AW-1:0] waddr,
   input  logic [DW-1:0]     wdata,
   input  logic [DW-1:0]     wmask,
   input  logic [ARR_AW-1:0] raddr,
   output logic [DW-1:0]     rdata
);
   localparam int DEPTH = 1 << ARR_AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we) begin
         mem[waddr] <= (mem[waddr] & ~wmask) | (wdata & wmask);
      end
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/burst_wr_target.sv
module burst_wr_target #(
   parameter int DW      = 68,
   parameter int AW      = 14,
   parameter int ARR_AW  = 4,
   parameter int BLEN_W  = 8,
   parameter int MIDX_W  = 3,
   parameter int ID_W    = 5,
   parameter int ID_LSB  = 21,
   parameter int SEL_LSB = 19,
   parameter logic [ID_W-1:0] DEV_ID = 5'd3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [MIDX_W+2:0] cmd,
   input  logic [DW-1:0]     dq,
   output logic              eot_out,
   output logic              eot_oe,
   input  logic              cfg_we,
   input  logic [MIDX_W:0]   cfg_addr,
   input  logic [DW-1:0]     cfg_wdata,
   input  logic              rd_arr,
   input  logic [ARR_AW-1:0] rd_addr,
   output logic [DW-1:0]     rd_data
);
   import bwt_pkg::*;

   localparam int NARR = 2;

   if (DEV_ID == {ID_W{1'b1}}) begin : g_bad_id
      $error("DEV_ID must differ from the broadcast identity");
   end
   if (ARR_AW > AW) begin : g_bad_depth
      $error("array index wider than the burst address");
   end
   if (ID_LSB + ID_W > DW || SEL_LSB + 2 > ID_LSB) begin : g_bad_fields
      $error("routing fields do not fit the bus");
   end

   logic              is_write;
   logic              selected;
   arr_sel_e          dec_arr;
   logic [MIDX_W-1:0] dec_midx;
   logic              accept;
   logic              busy;
   logic              wr_en;
   arr_sel_e          arr_q;
   logic [MIDX_W-1:0] midx_q;
   logic [DW-1:0]     mask_word;
   logic [AW-1:0]     burst_addr;
   logic [BLEN_W-1:0] blen;
   logic [NARR-1:0]   arr_we;
   logic [DW-1:0]     arr_rd [NARR];

   bwt_cmd_decode #(
      .DW(DW), .ID_W(ID_W), .ID_LSB(ID_LSB), .SEL_LSB(SEL_LSB),
      .MIDX_W(MIDX_W), .DEV_ID(DEV_ID)
   ) u_dec (
      .cmd_valid (cmd_valid),
      .cmd       (cmd),
      .dq        (dq),
      .is_write  (is_write),
      .selected  (selected),
      .arr       (dec_arr),
      .midx      (dec_midx)
   );

   bwt_sequencer #(.BLEN_W(BLEN_W), .MIDX_W(MIDX_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (is_write),
      .start_sel  (selected),
      .start_arr  (dec_arr),
      .start_midx (dec_midx),
      .blen       (blen),
      .accept     (accept),
      .busy       (busy),
      .wr_en      (wr_en),
      .arr_q      (arr_q),
      .midx_q     (midx_q),
      .eot_out    (eot_out),
      .eot_oe     (eot_oe)
   );

   bwt_cfg_regs #(
      .DW(DW), .AW(AW), .BLEN_W(BLEN_W), .MIDX_W(MIDX_W), .LEN_LSB(CFG_LEN_LSB)
   ) u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we),
      .cfg_addr   (cfg_addr),
      .cfg_wdata  (cfg_wdata),
      .lock       (busy || accept),
      .inc        (wr_en),
      .midx       (midx_q),
      .mask_word  (mask_word),
      .burst_addr (burst_addr),
      .blen       (blen)
   );

   for (genvar g = 0; g < NARR; g++) begin : g_arr
      assign arr_we[g] = wr_en && (arr_q == arr_sel_e'(g));
      bwt_array #(.DW(DW), .ARR_AW(ARR_AW)) u_mem (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (arr_we[g]),
         .waddr (burst_addr[ARR_AW-1:0]),
         .wdata (dq),
         .wmask (mask_word),
         .raddr (rd_addr),
         .rdata (arr_rd[g])
      );
   end

   assign rd_data = rd_arr ? arr_rd[1] : arr_rd[0];
endmodule

// File: rtl/bwt_checker.sv
module bwt_checker #(
   parameter int AW = 14
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_en,
   input logic          busy,
   input logic          eot_out,
   input logic          eot_oe,
   input logic [AW-1:0] burst_addr,
   input logic [1:0]    arr_we
);
   AST_OE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eot_oe) |-> $past(wr_en)); // R6
   AST_HIGH_THEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (eot_oe && eot_out) |=> (eot_oe && !eot_out)); // R6
   AST_RELEASE_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(eot_oe) |-> !$past(eot_out)); // R6
   AST_ONE_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(arr_we)); // R3
   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && $past(wr_en)) |-> (burst_addr == $past(burst_addr) + AW'(1))); // R5
   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !$past(wr_en)) |-> $stable(burst_addr)); // R9
   AST_OE_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
      eot_oe |-> busy); // R8
endmodule

bind burst_wr_target bwt_checker #(.AW(AW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .busy       (busy),
   .eot_out    (eot_out),
   .eot_oe     (eot_oe),
   .burst_addr (burst_addr),
   .arr_we     (arr_we)
);

// File: tb/burst_wr_target_tb_top.sv
`timescale 1ns/1ps
module burst_wr_target_tb_top;
   localparam int DW = 68;
   localparam int AW = 14;
   localparam int ARR_AW = 4;
   localparam int DEPTH = 1 << ARR_AW;
   localparam logic [4:0] MY_ID = 5'd3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cmd_valid = 1'b0;
   logic [5:0]        cmd = '0;
   logic [DW-1:0]     dq = '0;
   logic              eot_out;
   logic              eot_oe;
   logic              cfg_we = 1'b0;
   logic [3:0]        cfg_addr = '0;
   logic [DW-1:0]     cfg_wdata = '0;
   logic              rd_arr = 1'b0;
   logic [ARR_AW-1:0] rd_addr = '0;
   logic [DW-1:0]     rd_data;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   logic [DW-1:0] m_mask [8];
   logic [DW-1:0] m_mem [2][DEPTH];
   logic [AW-1:0] m_addr = '0;
   logic [7:0]    m_len = '0;

   always #2 clk = ~clk;

   burst_wr_target #(.DW(DW), .AW(AW), .ARR_AW(ARR_AW), .DEV_ID(MY_ID)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd), .dq(dq),
      .eot_out(eot_out), .eot_oe(eot_oe), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .rd_arr(rd_arr), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   function automatic logic [DW-1:0] rnd68();
      logic [95:0] r;
      r = {$urandom(), $urandom(), $urandom()};
      return r[DW-1:0];
   endfunction

   function automatic bit exp_sel(logic [4:0] id, logic [1:0] asel);
      return ((id == MY_ID) || (id == 5'h1f)) && !asel[1];
   endfunction

   task automatic chk(bit ok, string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic cfg_write(logic [3:0] a, logic [DW-1:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      if (a < 8) m_mask[a[2:0]] = d;
      else if (a == 8) begin m_addr = d[AW-1:0]; m_len = d[23:16]; end
   endtask

   task automatic set_burst(logic [AW-1:0] a, logic [7:0] n);
      logic [DW-1:0] w;
      w = '0; w[AW-1:0] = a; w[23:16] = n;
      cfg_write(4'd8, w);
   endtask

   // one burst; k counts bus cycles, k=1 being the command cycle
   task automatic do_burst(logic [4:0] id, logic [1:0] asel, logic [2:0] midx,
                           bit noise, bit poke_cfg, string req);
      int n;
      bit sel;
      bit e_oe, e_out;
      logic [DW-1:0] w;
      n = (m_len == 0) ? 1 : int'(m_len);
      sel = exp_sel(id, asel);
      for (int k = 1; k <= n + 2; k++) begin
         @(negedge clk);
         e_oe  = sel && (k >= 3);
         e_out = e_oe && (k == n + 1);
         chk(eot_oe == e_oe, sel ? "R6" : "R8", $sformatf("eot_oe cycle %0d", k),
             DW'(eot_oe), DW'(e_oe));
         if (e_oe)
            chk(eot_out == e_out, "R6", $sformatf("eot_out cycle %0d", k),
                DW'(eot_out), DW'(e_out));
         cfg_we = 1'b0;
         if (k == 1) begin
            w = rnd68();
            w[25:21] = id; w[20:19] = asel;
            dq = w; cmd_valid = 1'b1; cmd = {midx, 1'b1, 2'b01};
         end else begin
            w = rnd68();
            dq = w;
            cmd_valid = noise ? 1'($urandom_range(0, 1)) : 1'b0;
            cmd = {3'($urandom_range(0, 7)), 1'b1, 2'b01};
            if (poke_cfg && k == 2) begin
               cfg_we = 1'b1; cfg_addr = 4'd8; cfg_wdata = rnd68();
            end
            if (k <= n + 1 && sel) begin
               m_mem[asel[0]][m_addr[ARR_AW-1:0]] =
                  (m_mem[asel[0]][m_addr[ARR_AW-1:0]] & ~m_mask[midx]) | (w & m_mask[midx]);
               m_addr = m_addr + AW'(1);
            end
         end
      end
      @(negedge clk);
      cmd_valid = 1'b0; cfg_we = 1'b0;
      chk(eot_oe == 1'b0, req, "eot_oe released after burst", DW'(eot_oe), '0);
   endtask

   task automatic check_arrays(string req);
      int bad;
      bad = 0;
      cmd_valid = 1'b0;
      for (int a = 0; a < 2; a++) begin
         for (int i = 0; i < DEPTH; i++) begin
            rd_arr = a[0]; rd_addr = ARR_AW'(i);
            #0.1;
            if (rd_data !== m_mem[a][i]) begin
               bad++;
               $display("FAIL %s array %0d entry %0d actual=%h expected=%h",
                        req, a, i, rd_data, m_mem[a][i]);
            end
         end
      end
      checks++;
      if (bad != 0) failures++;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      for (int i = 0; i < 8; i++) m_mask[i] = '0;
      for (int a = 0; a < 2; a++) for (int i = 0; i < DEPTH; i++) m_mem[a][i] = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(eot_oe == 1'b0, "R1", "eot_oe after reset", DW'(eot_oe), '0);
      chk(eot_out == 1'b0, "R1", "eot_out after reset", DW'(eot_out), '0);
      check_arrays("R1");
      // R1 mask words are zero: a burst with index 5 before loading changes nothing
      set_burst(14'd2, 8'd3);
      do_burst(MY_ID, 2'b00, 3'd5, 0, 0, "R1");
      check_arrays("R1");

      // R9 load mask words
      cfg_write(4'd0, {DW{1'b1}});
      cfg_write(4'd1, 68'h0_0000_0000_FFFF_0000);
      for (int i = 2; i < 8; i++) cfg_write(4'(i), rnd68());

      // R2 R4 own identity, data array, full mask
      set_burst(14'd5, 8'd3);
      do_burst(MY_ID, 2'b00, 3'd0, 0, 0, "R2");
      check_arrays("R4");
      // R3 R7 broadcast into mask array, length 0 acts as 1
      set_burst(14'd9, 8'd0);
      do_burst(5'h1f, 2'b01, 3'd2, 0, 0, "R7");
      check_arrays("R7");
      // R4 partial mask over existing data
      set_burst(14'd5, 8'd4);
      do_burst(MY_ID, 2'b00, 3'd1, 0, 0, "R4");
      check_arrays("R4");
      // R8 foreign identity with stray commands in the data cycles
      set_burst(14'd0, 8'd6);
      do_burst(5'd5, 2'b00, 3'd0, 1, 0, "R8");
      check_arrays("R8");
      // R3 reserved array code makes the device unselected
      do_burst(MY_ID, 2'b10, 3'd0, 0, 0, "R3");
      check_arrays("R3");
      // R5 R9 continuation without reprogramming, ignored burst-register write
      set_burst(14'd12, 8'd2);
      do_burst(MY_ID, 2'b00, 3'd0, 0, 1, "R9");
      do_burst(MY_ID, 2'b01, 3'd0, 0, 0, "R5");
      check_arrays("R5");
      // R5 wrap of the full address
      set_burst(14'd16382, 8'd4);
      do_burst(5'h1f, 2'b00, 3'd0, 0, 0, "R5");
      check_arrays("R5");

      // random mix, bursts back to back
      for (int t = 0; t < 40; t++) begin
         logic [4:0] id;
         case ($urandom_range(0, 3))
            0: id = MY_ID;
            1: id = 5'h1f;
            default: id = 5'($urandom_range(0, 30));
         endcase
         if ($urandom_range(0, 2) == 0)
            set_burst(AW'($urandom()), 8'($urandom_range(0, 12)));
         do_burst(id, 2'($urandom_range(0, 3)), 3'($urandom_range(0, 7)),
                  1'($urandom_range(0, 1)), 0, "R8");
         if (t % 8 == 7) check_arrays("R4");
      end
      check_arrays("R4");

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule